// File: doc/BRIEF.md
# SYSREF Phase Alignment Tracker

This block holds a local multiframe (8b/10b) or extended-multiblock (64b/66b) reference counter in step with periodic SYSREF alignment events. It reports a latched "aligned" status once the counter phase has proven stable. Each alignment event, accepted only while alignment is enabled, compares the running phase against zero. A mismatch restarts the counter and withdraws the aligned status. A match counts toward proving alignment. A separate pulse reports that a supporting clock was realigned, and this also withdraws the status.

The aligned status gates three downstream permissions: a one-shot strobe for lane-arrival capture, a level that releases the elastic buffer, and, in 8b/10b mode only, a level that permits SYNC de-assertion. In subclass 1 these permissions wait for the aligned status. In subclass 0 they follow the link enable alone. Clearing the link enable returns the whole block to its idle state, so lane-arrival capture can happen again.

Top module: `sysref_phase_tracker`

## Requirements
- R1: While `rst` is high or `link_en` was low at the last clock edge, `phase` is 0, `aligned` is 0 and `arrival_capture`, `ebuf_release` and `sync_release` are 0. Taking `link_en` low resets all state at the next edge.
- R2: While enabled and no event is accepted, `phase` increases by one per clock and returns to 0 on the edge after it reaches or exceeds `mf_len_m1`.
- R3: An accepted event (`align_en`=1, `sysref_evt`=1) seen with `phase` not 0 is an adjustment. The counter restarts as if the event cycle were phase 0, so the next `phase` is 1 (0 when `mf_len_m1`=0). The event also clears `aligned` and the clean-event count.
- R4: An accepted event seen with `phase`=0 is clean and adds one to the count. The second clean event since the last clear sets `aligned` on that edge.
- R5: A `clk_realign` pulse clears `aligned` and the count on the next edge, and takes precedence over a clean event in the same cycle.
- R6: With `align_en`=0, `sysref_evt` pulses change neither the phase sequence, nor the count, nor `aligned`.
- R7: Once set, `aligned` stays 1 through further clean events and through misaligned pulses arriving while `align_en`=0.
- R8: With `subclass1`=1, `ebuf_release` is 1 exactly when the link is enabled and `aligned`=1. With `subclass1`=0 it is 1 from the cycle after `link_en` is sampled high, whatever `aligned` is.
- R9: `arrival_capture` pulses for exactly one cycle, on the cycle after `ebuf_release` is first 1 within a link-enable period. It does not pulse again until `link_en` has been low and then high.
- R10: `sync_release` (1 = SYNC may be de-asserted) equals `ebuf_release` when `mode_64b`=0 and is 0 when `mode_64b`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Link enable; low holds the block idle |
| align_en | input | 1 | Lets SYSREF alignment events reach the counter |
| subclass1 | input | 1 | 1 = subclass 1 gating, 0 = subclass 0 |
| mode_64b | input | 1 | 0 = 8b/10b, 1 = 64b/66b |
| mf_len_m1 | input | PH_W | Multiframe length minus one |
| clk_realign | input | 1 | Pulse: a supporting clock was realigned by SYSREF |
| sysref_evt | input | 1 | Pulse: SYSREF alignment event |
| phase | output | PH_W | Reference counter phase |
| aligned | output | 1 | Latched alignment status |
| arrival_capture | output | 1 | One-shot lane-arrival capture strobe |
| ebuf_release | output | 1 | Elastic-buffer release permission |
| sync_release | output | 1 | SYNC de-assertion permission (8b/10b only) |

## Verification
`phase`, `aligned` and the internal enable all register their new value on the edge that samples the event, realign pulse or link enable, so they are due one cycle after the stimulus is driven. `ebuf_release` and `sync_release` are combinational on that state and on the static configuration, so they follow in the same cycle. `arrival_capture` comes one further edge later. The bench drives inputs 1 ns after each falling edge and compares every output against a behavioural model, updated on the rising edge, at the next falling edge. Directed checks read the outputs at the step the model predicts.

// File: rtl/fctrk_pkg.sv
package fctrk_pkg;

    // Line coding selector
    typedef enum logic {
        LM_8B10B  = 1'b0,
        LM_64B66B = 1'b1
    } lane_code_e;

    // Classification of one SYSREF alignment event at the counter
    typedef struct packed {
        logic seen;    // accepted event this cycle
        logic clean;   // event found phase at zero
        logic adjust;  // event forced a phase restart
    } sref_evt_t;

    // Clean events required before the status is raised
    localparam int unsigned CLEAN_NEEDED = 2;

    // Advance a phase value, wrapping at or beyond the last index
    function automatic int unsigned step_phase(input int unsigned cur,
                                               input int unsigned last);
        return (cur >= last) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/fctrk_refcnt.sv
module fctrk_refcnt
    import fctrk_pkg::*;
#(
    parameter int PH_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            link_en,
    input  logic            align_en,
    input  logic            sysref_evt,
    input  logic [PH_W-1:0] len_m1,
    output logic [PH_W-1:0] phase,
    output sref_evt_t       evt
);

    logic [PH_W-1:0] phase_n;
    logic            at_zero;

    assign at_zero    = (phase == '0);
    assign evt.seen   = link_en & align_en & sysref_evt;
    assign evt.clean  = evt.seen & at_zero;
    assign evt.adjust = evt.seen & ~at_zero;

    always_comb begin
        if (evt.seen)
            phase_n = PH_W'(step_phase(0, 32'(len_m1)));
        else
            phase_n = PH_W'(step_phase(32'(phase), 32'(len_m1)));
    end

    always_ff @(posedge clk) begin
        if (rst || !link_en)
            phase <= '0;
        else
            phase <= phase_n;
    end

    // R2: wrap at the programmed last index
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (link_en && !evt.seen && phase >= len_m1) |=> (phase == '0));

    // R2: plain advance below the last index
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (link_en && !evt.seen && phase < len_m1) |=> (phase == $past(phase) + 1'b1));

    // R3: an adjustment restarts the count from the event cycle
    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        evt.adjust |=> (phase == (($past(len_m1) == '0) ? '0 : PH_W'(1))));

endmodule

// File: rtl/fctrk_qual.sv
module fctrk_qual
    import fctrk_pkg::*;
#(
    parameter int NEED = CLEAN_NEEDED
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      link_en,
    input  logic      clk_realign,
    input  sref_evt_t evt,
    output logic      aligned
);

    localparam int CW = $clog2(NEED + 1);

    logic [CW-1:0] clean_cnt;
    logic          drop;

    assign drop = clk_realign | evt.adjust;

    always_ff @(posedge clk) begin
        if (rst || !link_en) begin
            clean_cnt <= '0;
            aligned   <= 1'b0;
        end else if (drop) begin
            clean_cnt <= '0;
            aligned   <= 1'b0;
        end else if (evt.clean) begin
            if (clean_cnt >= CW'(NEED - 1)) begin
                clean_cnt <= CW'(NEED);
                aligned   <= 1'b1;
            end else begin
                clean_cnt <= clean_cnt + 1'b1;
            end
        end
    end

    // R3: adjustment withdraws the status
    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        evt.adjust |=> !aligned);

    // R5: supporting-clock realignment withdraws the status
    a_r5_realign: assert property (@(posedge clk) disable iff (rst)
        (link_en && clk_realign) |=> !aligned);

    // R6 / R7: without an accepted event or realign the status holds
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (link_en && !evt.seen && !clk_realign) |=> $stable(aligned));

    // R4: status rises only on a clean event
    a_r4_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned) |-> $past(evt.clean));

endmodule

// File: rtl/fctrk_gate.sv
module fctrk_gate
    import fctrk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       link_en,
    input  logic       subclass1,
    input  lane_code_e mode,
    input  logic       aligned,
    output logic       arrival_capture,
    output logic       ebuf_release,
    output logic       sync_release
);

    logic en_q;
    logic cap_done;
    logic permit;

    assign permit       = en_q & (~subclass1 | aligned);
    assign ebuf_release = permit;
    assign sync_release = permit & (mode == LM_8B10B);

    always_ff @(posedge clk) begin
        if (rst || !link_en) begin
            en_q            <= 1'b0;
            cap_done        <= 1'b0;
            arrival_capture <= 1'b0;
        end else begin
            en_q            <= 1'b1;
            arrival_capture <= 1'b0;
            if (permit && !cap_done) begin
                arrival_capture <= 1'b1;
                cap_done        <= 1'b1;
            end
        end
    end

    // R9: the capture strobe lasts one cycle
    a_r9_single: assert property (@(posedge clk) disable iff (rst)
        arrival_capture |=> !arrival_capture);

    // R9: the capture strobe follows a release permission
    a_r9_after_release: assert property (@(posedge clk) disable iff (rst)
        arrival_capture |-> $past(ebuf_release));

endmodule

// File: rtl/sysref_phase_tracker.sv
module sysref_phase_tracker
    import fctrk_pkg::*;
#(
    parameter int PH_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            link_en,
    input  logic            align_en,
    input  logic            subclass1,
    input  logic            mode_64b,
    input  logic [PH_W-1:0] mf_len_m1,
    input  logic            clk_realign,
    input  logic            sysref_evt,
    output logic [PH_W-1:0] phase,
    output logic            aligned,
    output logic            arrival_capture,
    output logic            ebuf_release,
    output logic            sync_release
);

    sref_evt_t  evt;
    lane_code_e mode;

    assign mode = mode_64b ? LM_64B66B : LM_8B10B;

    fctrk_refcnt #(.PH_W(PH_W)) u_refcnt (
        .clk        (clk),
        .rst        (rst),
        .link_en    (link_en),
        .align_en   (align_en),
        .sysref_evt (sysref_evt),
        .len_m1     (mf_len_m1),
        .phase      (phase),
        .evt        (evt)
    );

    fctrk_qual #(.NEED(CLEAN_NEEDED)) u_qual (
        .clk         (clk),
        .rst         (rst),
        .link_en     (link_en),
        .clk_realign (clk_realign),
        .evt         (evt),
        .aligned     (aligned)
    );

    fctrk_gate u_gate (
        .clk             (clk),
        .rst             (rst),
        .link_en         (link_en),
        .subclass1       (subclass1),
        .mode            (mode),
        .aligned         (aligned),
        .arrival_capture (arrival_capture),
        .ebuf_release    (ebuf_release),
        .sync_release    (sync_release)
    );

    // R1: a low link enable returns everything to idle on the next edge
    a_r1_idle: assert property (@(posedge clk) disable iff (rst)
        !link_en |=> (phase == '0 && !aligned && !ebuf_release && !arrival_capture));

endmodule

// File: tb/sysref_phase_tracker_test.sv
`timescale 1ns/1ps
module sysref_phase_tracker_test;

    localparam int PH_W = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            link_en = 1'b0;
    logic            align_en = 1'b0;
    logic            subclass1 = 1'b0;
    logic            mode_64b = 1'b0;
    logic [PH_W-1:0] mf_len_m1 = 10'd7;
    logic            clk_realign = 1'b0;
    logic            sysref_evt = 1'b0;
    logic [PH_W-1:0] phase;
    logic            aligned;
    logic            arrival_capture;
    logic            ebuf_release;
    logic            sync_release;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sysref_phase_tracker #(.PH_W(PH_W)) uut (
        .clk(clk), .rst(rst), .link_en(link_en), .align_en(align_en),
        .subclass1(subclass1), .mode_64b(mode_64b), .mf_len_m1(mf_len_m1),
        .clk_realign(clk_realign), .sysref_evt(sysref_evt), .phase(phase),
        .aligned(aligned), .arrival_capture(arrival_capture),
        .ebuf_release(ebuf_release), .sync_release(sync_release)
    );

    // ---------------- behavioural reference ----------------
    int m_phase = 0, m_cnt = 0;
    bit m_al = 0, m_en = 0, m_cap = 0, m_capdone = 0;

    always @(posedge clk) begin
        int  nph, ncnt;
        bit  nal, ncap, ncapdone, ev, permit;
        if (rst || !link_en) begin
            m_phase <= 0; m_cnt <= 0; m_al <= 0;
            m_en <= 0; m_cap <= 0; m_capdone <= 0;
        end else begin
            ev = align_en && sysref_evt;
            if (ev) nph = (mf_len_m1 == 0) ? 0 : 1;
            else    nph = (m_phase >= int'(mf_len_m1)) ? 0 : m_phase + 1;
            ncnt = m_cnt; nal = m_al;
            if (clk_realign || (ev && m_phase != 0)) begin
                ncnt = 0; nal = 0;
            end else if (ev) begin
                ncnt = m_cnt + 1;
                if (ncnt >= 2) begin ncnt = 2; nal = 1; end
            end
            permit = m_en && (!subclass1 || m_al);
            ncap = 0; ncapdone = m_capdone;
            if (permit && !m_capdone) begin ncap = 1; ncapdone = 1; end
            m_phase <= nph; m_cnt <= ncnt; m_al <= nal;
            m_en <= 1; m_cap <= ncap; m_capdone <= ncapdone;
        end
    end

    function automatic bit m_ebuf();
        return m_en && (!subclass1 || m_al);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (!done) begin
            check("R2 phase",            int'(phase),          m_phase);
            check("R4 aligned",          int'(aligned),        int'(m_al));
            check("R9 arrival_capture",  int'(arrival_capture), int'(m_cap));
            check("R8 ebuf_release",     int'(ebuf_release),   int'(m_ebuf()));
            check("R10 sync_release",    int'(sync_release),   int'(m_ebuf() && !mode_64b));
        end
    end

    task automatic finish_up();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            finish_up();
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // drive one event pulse sampled while the model phase equals p
    task automatic fire_at(input int p, input bit realign = 1'b0);
        for (int i = 0; i < 2000 && m_phase != p; i++) step();
        sysref_evt  = 1'b1;
        clk_realign = realign;
        step();
        sysref_evt  = 1'b0;
        clk_realign = 1'b0;
    endtask

    initial begin
        steps(3);
        // R1: outputs idle in reset
        check("R1 reset phase", int'(phase), 0);
        check("R1 reset aligned", int'(aligned), 0);
        check("R1 reset ebuf", int'(ebuf_release), 0);
        rst = 1'b0;
        step();

        subclass1 = 1'b1; mode_64b = 1'b0; align_en = 1'b1; link_en = 1'b1;
        steps(2);
        check("R8 held until aligned", int'(ebuf_release), 0);
        check("R10 sync held", int'(sync_release), 0);

        fire_at(3);
        check("R3 restart phase", int'(phase), 1);
        check("R3 no status", int'(aligned), 0);

        fire_at(0);
        check("R4 one clean not enough", int'(aligned), 0);
        fire_at(0);
        check("R4 second clean sets", int'(aligned), 1);
        check("R8 release on aligned", int'(ebuf_release), 1);
        check("R10 sync in 8b10b", int'(sync_release), 1);
        step();
        check("R9 capture pulse", int'(arrival_capture), 1);
        step();
        check("R9 capture one cycle", int'(arrival_capture), 0);

        fire_at(0);
        check("R7 stays on clean", int'(aligned), 1);

        fire_at(5);
        check("R3 misaligned clears", int'(aligned), 0);
        check("R8 release drops", int'(ebuf_release), 0);
        fire_at(0);
        fire_at(0);
        check("R4 realigned", int'(aligned), 1);
        steps(3);
        check("R9 no second capture", int'(arrival_capture), 0);

        // R5: realign beats a simultaneous clean event
        fire_at(0, 1'b1);
        check("R5 realign clears", int'(aligned), 0);
        fire_at(0);
        check("R5 count was cleared", int'(aligned), 0);
        fire_at(0);
        check("R5 recovers", int'(aligned), 1);

        // R7 / R6: disabled alignment ignores misaligned pulses
        align_en = 1'b0;
        fire_at(4);
        check("R7 kept while disabled", int'(aligned), 1);
        check("R6 phase unaffected", int'(phase), 5);
        clk_realign = 1'b1; step(); clk_realign = 1'b0;
        check("R5 realign while disabled", int'(aligned), 0);
        fire_at(0);
        fire_at(0);
        check("R6 events ignored", int'(aligned), 0);
        align_en = 1'b1;
        fire_at(0);
        fire_at(0);
        check("R4 aligned again", int'(aligned), 1);

        // R1: link disable resets
        link_en = 1'b0;
        step();
        check("R1 phase cleared", int'(phase), 0);
        check("R1 aligned cleared", int'(aligned), 0);
        check("R1 release cleared", int'(ebuf_release), 0);

        // R8 / R9: subclass 0 releases without alignment, capture repeats
        subclass1 = 1'b0;
        link_en = 1'b1;
        step();
        check("R8 subclass0 release", int'(ebuf_release), 1);
        check("R8 subclass0 unaligned", int'(aligned), 0);
        step();
        check("R9 capture after re-enable", int'(arrival_capture), 1);
        mode_64b = 1'b1;
        step();
        check("R10 no sync in 64b66b", int'(sync_release), 0);
        check("R10 release still on", int'(ebuf_release), 1);

        // R2: other lengths
        mf_len_m1 = 10'd2;
        steps(10);
        mf_len_m1 = 10'd0;
        steps(2);
        check("R2 length one stays zero", int'(phase), 0);
        mf_len_m1 = 10'd5;
        fire_at(3);
        check("R3 restart at length six", int'(phase), 1);
        steps(12);

        link_en = 1'b0;
        steps(2);
        finish_up();
    end

endmodule